// File: doc/BRIEF.md
# SPI Master Transfer Engine

This block runs full-duplex 8-bit serial transfers as a bus master. A control input enables it and selects the clock polarity, the clock phase and a three-bit rate code. A one-cycle start strobe then launches a transfer of a transmit byte. The engine lowers the slave select line, produces eight SCK cycles and shifts the byte out on MOSI, most significant bit first. On the same clock edges it collects eight bits from MISO. When the transfer ends it presents the received byte and raises a one-cycle completion pulse.

The whole block runs in the system clock domain. SCK is built from a clock-enable tick that fires once per SCK half-period. The rate code is not monotonic: the all-ones code selects the fastest rate, where SCK toggles on every system clock. The other codes select progressively slower rates.

While disabled, the block holds SCK high regardless of the polarity setting, and it abandons any transfer in progress.

Top module: `spi_xfer_master`

## Requirements
- R1: While `en` is 0, `sck` is 1 whatever `cpol` is. A clock edge that samples `en` = 0 leaves `ss_n` = 1 and `mosi` = 0 and ends any transfer without a `rx_done` pulse. After reset, `ss_n` = 1, `mosi` = 0, `rx_done` = 0 and `rx_data` = 0.
- R2: While enabled and no transfer runs, `sck` equals the current `cpol`.
- R3: The SCK half-period is H system clocks. Rate code 3'b111 gives H = 1. Code c from 0 to 6 gives H = 2^(c+1), so code 0 gives 2 and code 6 gives 128. A transfer has exactly 16 SCK edges, one every H clocks.
- R4: The 8 transmit bits appear on `mosi` most significant bit first.
- R5: With `cpha` = 0, bit 7 is on `mosi` from the cycle `ss_n` falls. The master samples `miso` on leading (odd-numbered) edges. `mosi` changes on trailing (even-numbered) edges. `mosi` is 0 outside a transfer and after the 16th edge.
- R6: With `cpha` = 1, `mosi` is 0 until the first edge. It takes the next bit on each leading edge, and the master samples `miso` on trailing edges.
- R7: `ss_n` falls on the clock edge that accepts a start. SCK edge k appears k·H clocks later. `ss_n` rises H clocks after the 16th edge.
- R8: The received byte has its first captured bit in bit 7. It is on `rx_data` in the cycle `rx_done` is 1 and is held until the next completion.
- R9: `rx_done` is high for exactly one cycle per completed transfer, in the same cycle that `ss_n` returns to 1.
- R10: A start is accepted only at an edge where no transfer runs and `en` is 1. A start seen during a transfer, including at its final edge, is ignored. A start held high therefore launches the next transfer one clock after `rx_done`.
- R11: `cpol`, `cpha`, `rate_sel` and `tx_data` are captured when a start is accepted. Changing them during a transfer does not alter that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Peripheral enable |
| cpol | input | 1 | SCK idle level while enabled |
| cpha | input | 1 | Clock phase: 0 samples on leading edges, 1 on trailing edges |
| rate_sel | input | 3 | Coded SCK rate select |
| start | input | 1 | Start strobe for one transfer |
| tx_data | input | 8 | Byte to transmit |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| ss_n | output | 1 | Active-low slave select |
| rx_data | output | 8 | Last received byte |
| rx_done | output | 1 | One-cycle pulse when `rx_data` is new |

## Verification
The clock edge that completes a transfer (`rx_done` and `ss_n` rising) can coincide with a start strobe, and it can coincide with `en` falling. The bench holds `start` high across the last edge and expects the new transfer to begin exactly one clock after the done pulse. It also drops `en` in the middle of a transfer and expects SCK high at once, select released on the next edge and no done pulse. A per-clock reference model, built only from edge counts and half-period lengths, predicts every output in both cases.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

    // Half-period of SCK in system clocks for a given rate code.
    // The all-ones code is the fastest setting; the rest double per step.
    function automatic int unsigned spi_half_len(input logic [31:0] code,
                                                 input int unsigned sel_w);
        if (code == ((32'd1 << sel_w) - 32'd1))
            return 1;
        return 32'd1 << (code + 32'd1);
    endfunction

endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
    import spi_xfer_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] rate,
    output logic             tick
);
    localparam int HALF_MAX = 1 << ((1 << SEL_W) - 1);
    localparam int CNT_W    = (HALF_MAX > 1) ? $clog2(HALF_MAX) : 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        last  = CNT_W'(spi_half_len(32'(rate), SEL_W) - 1);
        tick  = run && (cnt_q == last);
        cnt_d = cnt_q;
        if (!run || tick)
            cnt_d = '0;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3: the counter never passes the terminal value of the selected rate
    a_r3_cnt_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        run && $stable(rate) |-> cnt_q <= last);

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              start,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [SEL_W-1:0]  rate_sel,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              miso,
    input  logic              tick,
    output logic [SEL_W-1:0]  rate_q,
    output logic              busy,
    output logic              sck_q,
    output logic              mosi,
    output logic              ss_n,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_done
);
    localparam int EDGES  = 2 * DATA_W;
    localparam int ECNT_W = $clog2(EDGES + 1);

    typedef struct packed {
        logic              busy;
        logic              ss_n;
        logic              sck;
        logic              mosi;
        logic              done;
        logic              cpol;
        logic              cpha;
        logic [SEL_W-1:0]  rate;
        logic [ECNT_W-1:0] ecnt;
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
        logic [DATA_W-1:0] rx_out;
    } eng_t;

    eng_t d, q;
    logic lead_edge;

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        lead_edge = ~q.ecnt[0];
        if (!q.busy) begin
            if (en && start) begin
                d.busy = 1'b1;
                d.ss_n = 1'b0;
                d.cpol = cpol;
                d.cpha = cpha;
                d.rate = rate_sel;
                d.ecnt = '0;
                d.sck  = cpol;
                d.rx   = '0;
                if (cpha) begin
                    d.mosi = 1'b0;
                    d.tx   = tx_data;
                end else begin
                    d.mosi = tx_data[DATA_W-1];
                    d.tx   = {tx_data[DATA_W-2:0], 1'b0};
                end
            end
        end else if (!en) begin
            d.busy = 1'b0;
            d.ss_n = 1'b1;
            d.mosi = 1'b0;
        end else if (tick) begin
            if (q.ecnt == ECNT_W'(EDGES)) begin
                d.busy   = 1'b0;
                d.ss_n   = 1'b1;
                d.mosi   = 1'b0;
                d.done   = 1'b1;
                d.rx_out = q.rx;
            end else begin
                d.sck  = ~q.sck;
                d.ecnt = q.ecnt + 1'b1;
                if (lead_edge ^ q.cpha) begin
                    d.rx = {q.rx[DATA_W-2:0], miso};
                end else begin
                    d.mosi = q.tx[DATA_W-1];
                    d.tx   = {q.tx[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.ss_n <= 1'b1;
            q.sck  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rate_q  = q.rate;
    assign busy    = q.busy;
    assign sck_q   = q.sck;
    assign mosi    = q.mosi;
    assign ss_n    = q.ss_n;
    assign rx_data = q.rx_out;
    assign rx_done = q.done;

    // R9: completion pulse lasts a single cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);

    // R1: a disabled edge leaves select released
    a_r1_disable_releases: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ss_n);

    // R7: a normal release of select only follows all sixteen edges
    a_r7_release_after_edges: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ss_n) && $past(en) |-> q.ecnt == ECNT_W'(EDGES));

    // R11: captured settings hold for the whole transfer
    a_r11_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(q.cpol) && $stable(q.cpha) && $stable(rate_q));

    // R3: each tick inside the edge budget moves SCK
    a_r3_tick_moves_sck: assert property (@(posedge clk) disable iff (!rst_n)
        busy && en && tick && q.ecnt < ECNT_W'(EDGES) |=> sck_q != $past(sck_q));

endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master #(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [SEL_W-1:0]  rate_sel,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic              ss_n,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_done
);
    logic             tick;
    logic             busy;
    logic             sck_q;
    logic [SEL_W-1:0] rate_q;

    spi_rate_gen #(.SEL_W(SEL_W)) u_rate (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .rate  (rate_q),
        .tick  (tick)
    );

    spi_shift_engine #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .start    (start),
        .cpol     (cpol),
        .cpha     (cpha),
        .rate_sel (rate_sel),
        .tx_data  (tx_data),
        .miso     (miso),
        .tick     (tick),
        .rate_q   (rate_q),
        .busy     (busy),
        .sck_q    (sck_q),
        .mosi     (mosi),
        .ss_n     (ss_n),
        .rx_data  (rx_data),
        .rx_done  (rx_done)
    );

    // Disabled forces high; idle follows the live polarity; transfers use the engine level.
    assign sck = !en ? 1'b1 : (busy ? sck_q : cpol);

endmodule

// File: tb/spi_xfer_master_bench.sv
module spi_xfer_master_bench;
    logic       clk = 1'b0, rst_n = 1'b0, en = 1'b0, cpol = 1'b0, cpha = 1'b0;
    logic       start = 1'b0, miso = 1'b0;
    logic [2:0] rate_sel = 3'd0;
    logic [7:0] tx_data = 8'h00;
    logic       sck, mosi, ss_n, rx_done;
    logic [7:0] rx_data;

    always #2 clk = ~clk;

    spi_xfer_master u_spi_xfer_master (
        .clk(clk), .rst_n(rst_n), .en(en), .cpol(cpol), .cpha(cpha),
        .rate_sel(rate_sel), .start(start), .tx_data(tx_data), .miso(miso),
        .sck(sck), .mosi(mosi), .ss_n(ss_n), .rx_data(rx_data), .rx_done(rx_done)
    );

    int total = 0, failed = 0, cycles = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference model: transfer position r in clocks, half-period h
    bit         m_busy = 0, m_done = 0, l_cpol = 0, l_cpha = 0;
    int         r = 0, h = 1;
    logic [7:0] l_tx = 0, l_rx = 0, m_rx = 0, s_byte = 0;

    always @(posedge clk) begin
        cycles++;
        m_done = 0;
        if (!rst_n) m_busy = 0;
        else if (m_busy) begin
            if (!en) m_busy = 0;
            else begin
                r++;
                if (r == 17 * h) begin m_busy = 0; m_done = 1; m_rx = l_rx; end
            end
        end else if (en && start) begin
            m_busy = 1; r = 0;
            h = (rate_sel == 3'd7) ? 1 : (2 << rate_sel);
            l_cpol = cpol; l_cpha = cpha; l_tx = tx_data; l_rx = s_byte;
        end
    end

    // per-clock comparison, then slave model
    int         s_cnt = 0;
    logic       s_prev = 1'b1;
    logic [7:0] s_got = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            int e, idx;
            logic xs, xm;
            e  = m_busy ? ((r / h) > 16 ? 16 : r / h) : 0;
            xs = !en ? 1'b1 : (m_busy ? (l_cpol ^ e[0]) : cpol);
            chk(sck === xs, !en ? "R1 sck" : (m_busy ? "R3 sck" : "R2 sck"), sck, xs);
            chk(ss_n === !m_busy, "R7 ss_n", ss_n, !m_busy);
            xm = 1'b0;
            if (m_busy) begin
                if (!l_cpha) begin idx = e / 2; if (idx < 8) xm = l_tx[7 - idx]; end
                else begin idx = (e + 1) / 2; if (idx > 0) xm = l_tx[8 - idx]; end
            end
            chk(mosi === xm, l_cpha ? "R6 mosi" : "R5 mosi", mosi, xm);
            chk(rx_done === m_done, "R9 done", rx_done, m_done);
            if (m_done) chk(rx_data === m_rx, "R8 rx_data", rx_data, m_rx);
        end
        if (ss_n) begin
            s_cnt = 0; s_prev = sck; miso = 1'b0;
        end else begin
            if (sck !== s_prev) begin
                s_cnt++; s_prev = sck;
                if ((!l_cpha && s_cnt % 2 == 1) || (l_cpha && s_cnt % 2 == 0))
                    s_got = {s_got[6:0], mosi};
            end
            if (!l_cpha) miso = (s_cnt / 2 < 8) ? s_byte_l(7 - s_cnt / 2) : 1'b0;
            else         miso = ((s_cnt + 1) / 2 > 0) ? s_byte_l(8 - (s_cnt + 1) / 2) : 1'b0;
        end
    end

    function automatic logic s_byte_l(input int i);
        return l_rx[i];
    endfunction

    task automatic wait_done();
        while (!m_done) begin @(posedge clk); #1; end
    endtask

    task automatic xfer(input bit p, input bit ph, input logic [2:0] rs,
                        input logic [7:0] t, input logic [7:0] sb);
        @(posedge clk); #1;
        cpol = p; cpha = ph; rate_sel = rs; tx_data = t; s_byte = sb; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        wait_done();
        chk(s_got === t, "R4 mosi order", s_got, t);
        chk(rx_data === sb, "R8 received byte", rx_data, sb);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(sck === 1'b1, "R1 reset sck", sck, 1);
        chk(ss_n === 1'b1, "R1 reset ss_n", ss_n, 1);
        chk(mosi === 1'b0, "R1 reset mosi", mosi, 0);
        chk(rx_done === 1'b0, "R1 reset done", rx_done, 0);
        chk(rx_data === 8'h00, "R1 reset rx_data", rx_data, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        en = 1'b1; cpol = 1'b0;
        #1 chk(sck === 1'b0, "R2 idle low", sck, 0);
        cpol = 1'b1;
        #1 chk(sck === 1'b1, "R2 idle high", sck, 1);

        // all four clock modes at the fastest code
        xfer(0, 0, 3'd7, 8'hA5, 8'h3C);
        xfer(0, 1, 3'd7, 8'h81, 8'h7E);
        xfer(1, 0, 3'd7, 8'h5A, 8'hC3);
        xfer(1, 1, 3'd7, 8'h01, 8'h80);
        // every divider code (R3)
        for (int c = 0; c < 7; c++)
            xfer(c[0], c[1], 3'(c), 8'(8'h13 * (c + 1)), 8'(8'hF0 - c));

        // R10 and R11: start and setting changes during a transfer
        @(posedge clk); #1;
        cpol = 0; cpha = 0; rate_sel = 3'd1; tx_data = 8'hC9; s_byte = 8'h96; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        repeat (9) @(posedge clk);
        #1;
        cpol = 1; cpha = 1; rate_sel = 3'd7; tx_data = 8'h00; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        wait_done();
        chk(s_got === 8'hC9, "R10 start during busy ignored", s_got, 8'hC9);
        chk(rx_data === 8'h96, "R11 settings held", rx_data, 8'h96);

        // R10: start held across completion gives back-to-back transfers
        @(posedge clk); #1;
        cpol = 0; cpha = 1; rate_sel = 3'd0; tx_data = 8'h6D; s_byte = 8'h2B; start = 1'b1;
        @(posedge clk); #1;
        wait_done();
        tx_data = 8'hB2; s_byte = 8'hD4;
        @(posedge clk); #1;
        chk(ss_n === 1'b0, "R10 back-to-back restart", ss_n, 0);
        start = 1'b0;
        wait_done();
        chk(rx_data === 8'hD4, "R10 second byte", rx_data, 8'hD4);

        // R1: disable mid-transfer
        @(posedge clk); #1;
        cpol = 0; cpha = 0; rate_sel = 3'd2; tx_data = 8'hFF; s_byte = 8'h11; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        repeat (21) @(posedge clk);
        #1;
        en = 1'b0;
        #1 chk(sck === 1'b1, "R1 sck high when disabled", sck, 1);
        @(posedge clk); #1;
        chk(ss_n === 1'b1, "R1 select released", ss_n, 1);
        chk(mosi === 1'b0, "R1 mosi cleared", mosi, 0);
        repeat (40) @(posedge clk);
        #1;
        chk(rx_done === 1'b0, "R1 no done after abort", rx_done, 0);
        en = 1'b1;
        xfer(1, 0, 3'd7, 8'h4E, 8'hE4);

        repeat (4) @(posedge clk);
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        failed++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule